// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Emulator

This block is a synthesizable stand-in for a 16-bit asynchronous static RAM, built to act as a bench target inside a synchronous design. The memory's active-low control pins reach it unregistered: chip select, write strobe, output enable and one enable per byte lane. The address and the write data bus arrive the same way. A fast internal clock samples all of them through a two-flop synchronizer. From the synchronized pins the block decodes the access mode. It writes only the byte lanes that were enabled. It returns stored data only on the lanes a read selects, and it reports for each lane whether that lane would be driving the bus.

A write lasts exactly as long as chip select, the write strobe and at least one lane enable are all low at the same time. The cycle in which that combined term drops is the end of the write. Address, data and lane selection are all taken from the last synchronized cycle in which the write was still active. Analog timing, power states and retention are not modelled. The storage is a plain register array whose depth is a parameter.

Top module: `asram_lane_model`

## Requirements
- R1: While chip select (`ceN`) is high, no lane is driven (`laneDrive` is 0), whatever the other pins do, and no write takes place.
- R2: With `ceN` low and both lane enables high (`byteEnN` = 2'b11), no lane is driven, even when a read is requested.
- R3: With `ceN` low, `weN` high and `oeN` low, `laneDrive` equals the inverse of `byteEnN`. Lane 1 (enable `byteEnN[1]`) owns `rdData[15:8]` and lane 0 owns `rdData[7:0]`. Each driven lane shows the word stored at `addr`.
- R4: With `ceN` and `weN` both low, no lane is driven, whether `oeN` is high or low.
- R5: With `ceN` low and both `weN` and `oeN` high, no lane is driven and the stored contents do not change.
- R6: A write is active only while `ceN`, `weN` and at least one `byteEnN` bit are all low. The first of these to go inactive ends it. A strobe with both lane enables high stores nothing.
- R7: The write stores the address, the data and the lane selection of the last synchronized cycle in which the write was active. Lanes not selected in that cycle keep their old value.
- R8: A pin level applied before rising edge k is reflected on `laneDrive`/`rdData` after edge k+2. A read that follows a write directly returns the new data one cycle after the old.
- R9: A lane that is not driven reads as zero on `rdData`.
- R10: While `rstN` is low, `laneDrive` and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| byteEnN | input | 2 | Lane enables, active low; bit 1 is the upper byte |
| addr | input | AW (6) | Word address, AW = log2(DEPTH) |
| wrData | input | 16 | Write data bus |
| rdData | output | 16 | Read data, zero on undriven lanes |
| laneDrive | output | 2 | Per-lane output-drive flag; 1 means that lane is driving |

## Verification
A lane mask latched from the wrong cycle corrupts only the lane that changed enable at the end of a write, and this shows on the next read of that address. It appears three cycles after the read pins are applied. A stuck or mistimed write-active flag either drops a write or stores one twice with a stale address, which shows on the next read-back of either word. A decode error in the drive mask is visible on `laneDrive` three cycles after the offending pin combination appears. It is therefore compared on every clock against a model of the same pin history.

// File: rtl/asram_pkg.sv
package asram_pkg;
  // The emulated memory has two byte lanes; lane 1 is the upper byte
  localparam int LANES = 2;

  typedef logic [LANES-1:0] laneMask_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      commit;      // write ends this cycle: store the snapshot
    laneMask_t commitMask;  // lanes to update on commit
    laneMask_t driveMask;   // lanes a read would drive now
  } strobe_t;
endpackage

// File: rtl/asram_sync.sv
module asram_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      weN,
  input  logic      oeN,
  input  laneMask_t byteEnN,
  output strobe_t   strobes
);
  localparam int PW = 3 + LANES;

  logic [PW-1:0] pinSync;
  logic          ceS, weS, oeS;
  laneMask_t     beS;

  // Idle level of every control pin is high
  asram_sync #(.W(PW), .RST_VAL({PW{1'b1}})) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({ceN, weN, oeN, byteEnN}),
    .syncOut(pinSync)
  );

  assign {ceS, weS, oeS, beS} = pinSync;

  logic      writeNow;
  logic      writePrev;
  laneMask_t maskPrev;

  assign writeNow = !ceS && !weS && (beS != {LANES{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writePrev <= 1'b0;
      maskPrev  <= '0;
    end else begin
      writePrev <= writeNow;
      maskPrev  <= ~beS;
    end
  end

  always_comb begin
    strobes.commit     = writePrev && !writeNow;
    strobes.commitMask = maskPrev;
    strobes.driveMask  = (!ceS && weS && !oeS) ? ~beS : '0;
  end
endmodule

// File: rtl/asram_data.sv
module asram_data
  import asram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH),
  parameter int DW     = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  strobe_t       strobes,
  output logic [DW-1:0] rdData,
  output laneMask_t     laneDrive
);
  logic [AW+DW-1:0] busSync;
  logic [AW-1:0]    addrS, addrPrev;
  logic [DW-1:0]    dataS, dataPrev;

  asram_sync #(.W(AW + DW), .RST_VAL('0)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({addr, wrData}),
    .syncOut(busSync)
  );

  assign {addrS, dataS} = busSync;

  // Snapshot of the previous synchronized cycle, used when a write ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPrev <= '0;
      dataPrev <= '0;
    end else begin
      addrPrev <= addrS;
      dataPrev <= dataS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) laneDrive <= '0;
    else       laneDrive <= strobes.driveMask;
  end

  for (genvar g = 0; g < LANES; g++) begin : laneGen
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.commit && strobes.commitMask[g])
        laneMem[addrPrev] <= dataPrev[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdData[g*LANE_W +: LANE_W] <= '0;
      else if (strobes.driveMask[g])
        rdData[g*LANE_W +: LANE_W] <= laneMem[addrS];
      else
        rdData[g*LANE_W +: LANE_W] <= '0;
    end
  end
endmodule

// File: rtl/asram_lane_model.sv
module asram_lane_model
  import asram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [LANES-1:0] byteEnN,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic [LANES-1:0] laneDrive
);
  strobe_t strobes;

  asram_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .weN    (weN),
    .oeN    (oeN),
    .byteEnN(byteEnN),
    .strobes(strobes)
  );

  asram_data #(.DEPTH(DEPTH), .LANE_W(LANE_W), .AW(AW), .DW(DW)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrData   (wrData),
    .strobes  (strobes),
    .rdData   (rdData),
    .laneDrive(laneDrive)
  );
endmodule

// File: rtl/asram_chk.sv
module asram_chk
  import asram_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int DW     = LANES * LANE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             ceN,
  input logic             weN,
  input logic             oeN,
  input logic [LANES-1:0] byteEnN,
  input logic [DW-1:0]    rdData,
  input logic [LANES-1:0] laneDrive
);
  // Cycles since reset release, saturating; pin history is valid from 4
  logic [2:0] warm;
  logic       ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  assign ready = (warm == 3'd4);

  // R1
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ceN, 3)) |-> (laneDrive == '0));

  // R2
  no_lane_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(ceN, 3) && ($past(byteEnN, 3) == {LANES{1'b1}})) |-> (laneDrive == '0));

  // R3
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(ceN, 3) && $past(weN, 3) && !$past(oeN, 3))
      |-> (laneDrive == ~$past(byteEnN, 3)));

  // R4
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(ceN, 3) && !$past(weN, 3)) |-> (laneDrive == '0));

  // R5
  out_off_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(ceN, 3) && $past(weN, 3) && $past(oeN, 3)) |-> (laneDrive == '0));

  for (genvar g = 0; g < LANES; g++) begin : laneChk
    // R9
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !laneDrive[g] |-> (rdData[g*LANE_W +: LANE_W] == '0));
  end
endmodule

bind asram_lane_model asram_chk #(.LANE_W(LANE_W), .DW(DW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .weN      (weN),
  .oeN      (oeN),
  .byteEnN  (byteEnN),
  .rdData   (rdData),
  .laneDrive(laneDrive)
);

// File: tb/sim_asram_lane_model.sv
`timescale 1ns/1ps
module sim_asram_lane_model;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [1:0]  byteEnN = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  laneDrive;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  asram_lane_model u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .byteEnN(byteEnN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .laneDrive(laneDrive)
  );

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic ce, we, oe;
    logic [1:0] be;
    logic [AW-1:0] a;
    logic [15:0] d;
  } pin_t;

  localparam pin_t IDLE = '{ce: 1'b1, we: 1'b1, oe: 1'b1, be: 2'b11, a: '0, d: '0};

  pin_t        hist[$];
  logic [7:0]  mm [int];
  logic [1:0]  expDrive = '0;
  logic [15:0] expData = '0;
  logic [1:0]  expKnown = 2'b11;
  string       expTag = "R10";

  function automatic bit writing(pin_t p);
    return !p.ce && !p.we && (p.be != 2'b11);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{IDLE, IDLE, IDLE, IDLE};
      expDrive = '0; expData = '0; expKnown = 2'b11; expTag = "R10";
    end else begin
      pin_t s, p;
      hist.push_front('{ce: ceN, we: weN, oe: oeN, be: byteEnN, a: addr, d: wrData});
      void'(hist.pop_back());
      s = hist[2];
      p = hist[3];
      if (s.ce) expTag = "R1";
      else if (s.be == 2'b11) expTag = "R2";
      else if (!s.we) expTag = "R4";
      else if (s.oe) expTag = "R5";
      else expTag = "R3";
      expDrive = (!s.ce && s.we && !s.oe) ? ~s.be : 2'b00;
      expData = '0; expKnown = 2'b11;
      for (int i = 0; i < 2; i++) begin
        if (expDrive[i]) begin
          if (mm.exists(int'(s.a) * 2 + i)) expData[i*8 +: 8] = mm[int'(s.a) * 2 + i];
          else expKnown[i] = 1'b0;
        end
      end
      // write commits after the read has used the old contents
      if (writing(p) && !writing(s)) begin
        for (int i = 0; i < 2; i++)
          if (!p.be[i]) mm[int'(p.a) * 2 + i] = p.d[i*8 +: 8];
      end
    end
  end

  // every-clock comparison at the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      nTests++;
      if (laneDrive !== expDrive) begin
        nFail++;
        $display("FAIL %s laneDrive act=%b exp=%b t=%0t", expTag, laneDrive, expDrive, $time);
      end
      for (int i = 0; i < 2; i++) begin
        if (expKnown[i] && rdData[i*8 +: 8] !== expData[i*8 +: 8]) begin
          nFail++;
          $display("FAIL %s lane%0d rdData act=%h exp=%h t=%0t",
                   expDrive[i] ? "R7" : "R9", i, rdData[i*8 +: 8], expData[i*8 +: 8], $time);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic c, logic w, logic o, logic [1:0] b,
                       logic [AW-1:0] a, logic [15:0] d, int n);
    ceN = c; weN = w; oeN = o; byteEnN = b; addr = a; wrData = d;
    repeat (n) @(negedge clk);
  endtask

  // ender: 0 strobe rises, 1 select rises, 2 lane enables rise
  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic [1:0] b, int ender);
    drive(0, 0, 1, b, a, d, 3);
    case (ender)
      0: drive(0, 1, 1, b, a, d, 1);
      1: drive(1, 0, 1, b, a, d, 1);
      default: drive(0, 0, 1, 2'b11, a, d, 1);
    endcase
    drive(1, 1, 1, 2'b11, '0, '0, 2);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [1:0] b);
    drive(0, 1, 0, b, a, 16'h0000, 4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10
    chk("R10", {14'd0, laneDrive}, 16'h0000);
    chk("R10", rdData, 16'h0000);
    rstN = 1'b1;
    drive(1, 1, 1, 2'b11, '0, '0, 4);

    // R6: writes ended by each of the three terminating pins
    for (int a = 0; a < 8; a++)
      wr(AW'(a), {8'hA0 + 8'(a), 8'h50 + 8'(a)}, 2'b00, a % 3);
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), 2'b00);
      chk("R3", rdData, {8'hA0 + 8'(a), 8'h50 + 8'(a)});
      chk("R3", {14'd0, laneDrive}, 16'h0003);
    end

    // R7: upper lane only
    wr(2, 16'h5AEE, 2'b01, 0);
    rd(2, 2'b00);
    chk("R7", rdData, 16'h5A52);

    // R6: strobe with no lane enabled stores nothing
    wr(3, 16'hFFFF, 2'b11, 0);
    rd(3, 2'b00);
    chk("R6", rdData, 16'hA353);

    // R4: write with output enable low
    drive(0, 0, 0, 2'b00, 4, 16'h1234, 4);
    chk("R4", {14'd0, laneDrive}, 16'h0000);
    drive(0, 1, 1, 2'b00, 4, 16'h1234, 1);
    drive(1, 1, 1, 2'b11, 0, 0, 2);
    rd(4, 2'b00);
    chk("R4", rdData, 16'h1234);

    // R5: outputs off, bus noise does not change contents
    drive(0, 1, 1, 2'b00, 5, 16'hDEAD, 4);
    chk("R5", {14'd0, laneDrive}, 16'h0000);
    rd(5, 2'b00);
    chk("R5", rdData, 16'hA555);

    // R1: deselected with write and read pins active
    drive(1, 0, 0, 2'b00, 6, 16'hBEEF, 4);
    chk("R1", {14'd0, laneDrive}, 16'h0000);
    drive(1, 1, 1, 2'b11, 0, 0, 2);
    rd(6, 2'b00);
    chk("R1", rdData, 16'hA656);

    // R2: read with both lane enables high
    drive(0, 1, 0, 2'b11, 1, 0, 4);
    chk("R2", {14'd0, laneDrive}, 16'h0000);

    // R3 / R9: single-lane reads
    rd(1, 2'b10);
    chk("R3", {14'd0, laneDrive}, 16'h0001);
    chk("R9", rdData, 16'h0051);
    rd(1, 2'b01);
    chk("R3", {14'd0, laneDrive}, 16'h0002);
    chk("R9", rdData, 16'hA100);

    // R7: lane mask and data change in the last active cycle
    drive(0, 0, 1, 2'b00, 7, 16'h1111, 3);
    drive(0, 0, 1, 2'b10, 7, 16'h2233, 1);
    drive(0, 1, 1, 2'b10, 7, 16'h2233, 1);
    drive(1, 1, 1, 2'b11, 0, 0, 2);
    rd(7, 2'b00);
    chk("R7", rdData, 16'hA733);

    // R8: pin-to-output latency
    drive(1, 1, 1, 2'b11, 0, 0, 3);
    ceN = 0; weN = 1; oeN = 0; byteEnN = 2'b00; addr = 1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    chk("R8", {14'd0, laneDrive}, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R8", {14'd0, laneDrive}, 16'h0003);
    chk("R8", rdData, 16'hA151);

    // R8: read straight after write to the same word
    drive(0, 0, 1, 2'b00, 0, 16'h7788, 3);
    drive(0, 1, 0, 2'b00, 0, 16'h7788, 4);
    chk("R8", rdData, 16'h7788);

    drive(1, 1, 1, 2'b11, 0, 0, 4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule